// File: doc/BRIEF.md
# Bus Address Reference Monitor

This block is a policy checker placed between two bus masters and a shared address space. Every request carries a master identifier, a read/write flag and an address. The monitor compares the address against a fixed table of ten inclusive windows, all of them in parallel. It then decides whether the request may pass, using the window hits, the requesting master, the access kind and the current owner of a shared crypto engine. A granted request is forwarded exactly one clock later. A denied request is dropped and raises a one-cycle violation pulse.

Access rights change over time. A master takes exclusive use of the crypto engine's register space by writing its claim word. The owner hands the engine back by writing its release word. While a master holds the engine it gains rights on the engine windows. The other master keeps only its base rights. The window table and the per-state rights are fixed at elaboration. The monitor has no programming interface.

Top module: `bus_ref_monitor`

## Requirements
- R1: A synchronous active-high reset clears the forwarded-access and violation outputs to 0 and sets `owner_state` to 2'b00 (no owner). This holds even when a master owned the engine before the reset. `owner_state` encodes 2'b01 as owned by master A (`req_master`=0) and 2'b10 as owned by master B (`req_master`=1).
- R2: Each request sampled with `req_valid`=1 produces its decision on the next clock edge and at no other time. On a grant, `fwd_valid`=1 and `fwd_master`/`fwd_write`/`fwd_addr` carry the request fields. A cycle without a request produces neither `fwd_valid` nor `chk_violation`.
- R3: With no owner, the following rights apply. Both masters may read and write window W0 = 0x41400000..0x4140FFFF. Only master A may read and write W3 = 0x24000000..0x24777777 and W5 = 0x40600000..0x4060FFFF. Only master B may read and write W4 = 0x24800000..0x24FFFFFF and W6 = 0x40C00000..0x40C0FFFF. Either master may only write the claim word W7 = 0x28000004..0x28000007.
- R4: With no owner, a granted write by master A to W7 sets `owner_state` to 2'b01. In that state master A also has read/write on W1 = 0x28000000..0x28000777 and on W9 = 0x28000000..0x28000003, and write-only on the release word W8 = 0x28000008..0x2800000F.
- R5: With no owner, a granted write by master B to W7 sets `owner_state` to 2'b10. In that state master B also has read/write on W2 = 0x28000800..0x28000FFF and on W9, and write-only on W8.
- R6: A granted write to W8 by the current owner returns `owner_state` to 2'b00. A write to W8 by a master that does not own the engine is denied and changes nothing, and so is any write to W8 while nobody owns it.
- R7: A denied request gives `chk_violation`=1 for exactly one cycle, with `fwd_valid`=0 and `owner_state` unchanged.
- R8: Reads never change `owner_state`, including reads of W7, W8 and W9. In an owner state, a write to W7 gives no right of its own and never moves the owner directly to the other master.
- R9: A request is granted when any window that is permitted for the current state, master and access kind contains the address. Overlapping windows count, so an owner's access to W7 or W8 inside W1 is granted through W1 without a state change unless R6 applies. An address outside every permitted window is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | 1 | 0 = master A, 1 = master B |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| fwd_valid | output | 1 | Granted access forwarded (one cycle after request) |
| fwd_master | output | 1 | Master of forwarded access |
| fwd_write | output | 1 | Kind of forwarded access |
| fwd_addr | output | ADDR_W | Address of forwarded access |
| chk_violation | output | 1 | One-cycle pulse for a denied request |
| owner_state | output | 2 | 00 none, 01 master A owns engine, 10 master B owns engine |

## Verification
A wrong owner state shows up on `owner_state` on the edge right after the offending write. It also flips the grant and deny decision for engine-window accesses on the very next request. The bench therefore follows each claim, release or refused write with probes of W1, W2, W8 and W9 from both masters. A wrong window bound shows only for an address at that bound, so the stimulus table places addresses exactly on the window edges and one past them.

// File: rtl/rm_pkg.sv
package rm_pkg;

   localparam int RM_TABLE_RANGES = 10;

   typedef enum logic [1:0] {
      OWN_NONE = 2'b00,
      OWN_A    = 2'b01,
      OWN_B    = 2'b10
   } own_e;

   // inclusive lower bound of window i
   function automatic logic [31:0] win_lo(input int i);
      case (i)
         0:       win_lo = 32'h4140_0000;
         1:       win_lo = 32'h2800_0000;
         2:       win_lo = 32'h2800_0800;
         3:       win_lo = 32'h2400_0000;
         4:       win_lo = 32'h2480_0000;
         5:       win_lo = 32'h4060_0000;
         6:       win_lo = 32'h40C0_0000;
         7:       win_lo = 32'h2800_0004;
         8:       win_lo = 32'h2800_0008;
         9:       win_lo = 32'h2800_0000;
         default: win_lo = 32'hFFFF_FFFF;
      endcase
   endfunction

   // inclusive upper bound of window i
   function automatic logic [31:0] win_hi(input int i);
      case (i)
         0:       win_hi = 32'h4140_FFFF;
         1:       win_hi = 32'h2800_0777;
         2:       win_hi = 32'h2800_0FFF;
         3:       win_hi = 32'h2477_7777;
         4:       win_hi = 32'h24FF_FFFF;
         5:       win_hi = 32'h4060_FFFF;
         6:       win_hi = 32'h40C0_FFFF;
         7:       win_hi = 32'h2800_0007;
         8:       win_hi = 32'h2800_000F;
         9:       win_hi = 32'h2800_0003;
         default: win_hi = 32'h0000_0000;
      endcase
   endfunction

   // bit i set: window i may be used for this state/master/kind
   function automatic logic [RM_TABLE_RANGES-1:0] perm_mask(
      input own_e st, input logic master_b, input logic is_wr);
      logic [RM_TABLE_RANGES-1:0] m;
      m = master_b ? 10'h051 : 10'h029;          // base rights, read and write
      case (st)
         OWN_NONE: if (is_wr) m = m | 10'h080;   // claim word, write only
         OWN_A: if (!master_b) begin
            m = m | 10'h202;                     // engine window + data word
            if (is_wr) m = m | 10'h100;          // release word
         end
         OWN_B: if (master_b) begin
            m = m | 10'h204;
            if (is_wr) m = m | 10'h100;
         end
         default: m = '0;
      endcase
      perm_mask = m;
   endfunction

endpackage

// File: rtl/rm_range_match.sv
module rm_range_match #(
   parameter int ADDR_W     = 32,
   parameter int NUM_RANGES = 10
) (
   input  logic [ADDR_W-1:0]     addr,
   output logic [NUM_RANGES-1:0] hit
);
   import rm_pkg::*;

   if (ADDR_W < 32) begin : g_bad_width
      $error("rm_range_match: ADDR_W must be at least 32");
   end

   for (genvar i = 0; i < NUM_RANGES; i++) begin : g_win
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(win_lo(i));
      localparam logic [ADDR_W-1:0] HI = ADDR_W'(win_hi(i));
      if (win_lo(i) > win_hi(i)) begin : g_bad_win
         $error("rm_range_match: window with lower bound above upper bound");
      end
      // comparator variant chosen by bound: skip the lower compare at zero
      if (LO == '0) begin : g_hi_only
         assign hit[i] = (addr <= HI);
      end else if (LO == HI) begin : g_single
         assign hit[i] = (addr == LO);
      end else begin : g_both
         assign hit[i] = (addr >= LO) && (addr <= HI);
      end
   end
endmodule

// File: rtl/rm_perm_table.sv
module rm_perm_table #(
   parameter int NUM_RANGES = 10
) (
   input  rm_pkg::own_e          state,
   input  logic                  master_b,
   input  logic                  is_wr,
   input  logic [NUM_RANGES-1:0] hit,
   output logic                  grant
);
   import rm_pkg::*;

   if (NUM_RANGES != RM_TABLE_RANGES) begin : g_bad_count
      $error("rm_perm_table: NUM_RANGES must match the fixed policy table");
   end

   logic [NUM_RANGES-1:0] allow;

   always_comb begin
      allow = perm_mask(state, master_b, is_wr);
   end

   // deny by default; any permitted window hit grants
   assign grant = |(allow & hit);
endmodule

// File: rtl/rm_owner_fsm.sv
module rm_owner_fsm (
   input  logic         clk,
   input  logic         rst,
   input  logic         upd_en,     // granted write this cycle
   input  logic         master_b,
   input  logic         claim_hit,
   input  logic         release_hit,
   output rm_pkg::own_e state_q
);
   import rm_pkg::*;

   own_e state_d;

   always_comb begin
      state_d = state_q;
      if (upd_en) begin
         case (state_q)
            OWN_NONE: if (claim_hit) state_d = master_b ? OWN_B : OWN_A;
            OWN_A:    if (release_hit && !master_b) state_d = OWN_NONE;
            OWN_B:    if (release_hit &&  master_b) state_d = OWN_NONE;
            default:  state_d = OWN_NONE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= OWN_NONE;
      else     state_q <= state_d;
   end

   AST_NO_DIRECT_SWAP_A: assert property (@(posedge clk) disable iff (rst)
      (state_q == OWN_A) |=> (state_q != OWN_B)); // R8
   AST_NO_DIRECT_SWAP_B: assert property (@(posedge clk) disable iff (rst)
      (state_q == OWN_B) |=> (state_q != OWN_A)); // R8
   AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
      !upd_en |=> $stable(state_q)); // R7
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      $onehot0(state_q)); // R1
endmodule

// File: rtl/bus_ref_monitor.sv
module bus_ref_monitor #(
   parameter int ADDR_W      = 32,
   parameter int NUM_RANGES  = 10,
   parameter int CLAIM_IDX   = 7,
   parameter int RELEASE_IDX = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_master,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              fwd_valid,
   output logic              fwd_master,
   output logic              fwd_write,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              chk_violation,
   output logic [1:0]        owner_state
);
   import rm_pkg::*;

   if (CLAIM_IDX >= NUM_RANGES || RELEASE_IDX >= NUM_RANGES
       || CLAIM_IDX == RELEASE_IDX) begin : g_bad_idx
      $error("bus_ref_monitor: trigger window indices invalid");
   end

   logic [NUM_RANGES-1:0] hit;
   logic                  perm_ok;
   logic                  grant_now;
   own_e                  state_q;

   rm_range_match #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES)) u_match (
      .addr (req_addr),
      .hit  (hit)
   );

   rm_perm_table #(.NUM_RANGES(NUM_RANGES)) u_perm (
      .state    (state_q),
      .master_b (req_master),
      .is_wr    (req_write),
      .hit      (hit),
      .grant    (perm_ok)
   );

   assign grant_now = req_valid && perm_ok;

   rm_owner_fsm u_fsm (
      .clk         (clk),
      .rst         (rst),
      .upd_en      (grant_now && req_write),
      .master_b    (req_master),
      .claim_hit   (hit[CLAIM_IDX]),
      .release_hit (hit[RELEASE_IDX]),
      .state_q     (state_q)
   );

   // one-cycle decision stage
   always_ff @(posedge clk) begin
      if (rst) begin
         fwd_valid     <= 1'b0;
         fwd_master    <= 1'b0;
         fwd_write     <= 1'b0;
         fwd_addr      <= '0;
         chk_violation <= 1'b0;
      end else begin
         fwd_valid     <= grant_now;
         chk_violation <= req_valid && !perm_ok;
         if (grant_now) begin
            fwd_master <= req_master;
            fwd_write  <= req_write;
            fwd_addr   <= req_addr;
         end
      end
   end

   assign owner_state = state_q;

   AST_ONE_DECISION: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> (fwd_valid != chk_violation)); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> (!fwd_valid && !chk_violation)); // R2
   AST_DENY_KEEPS_OWNER: assert property (@(posedge clk) disable iff (rst)
      chk_violation |-> (owner_state == $past(owner_state))); // R7
   AST_READ_KEEPS_OWNER: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_write) |=> $stable(owner_state)); // R8
   AST_FWD_ADDR: assert property (@(posedge clk) disable iff (rst)
      grant_now |=> (fwd_addr == $past(req_addr))); // R2
endmodule

// File: tb/bus_ref_monitor_tb.sv
`timescale 1ns/1ps
module bus_ref_monitor_tb;

   localparam int AW = 32;
   localparam int NV = 33;

   logic          clk = 1'b0;
   logic          rst;
   logic          req_valid, req_master, req_write;
   logic [AW-1:0] req_addr;
   logic          fwd_valid, fwd_master, fwd_write, chk_violation;
   logic [AW-1:0] fwd_addr;
   logic [1:0]    owner_state;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   bus_ref_monitor u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_master(req_master),
      .req_write(req_write), .req_addr(req_addr), .fwd_valid(fwd_valid),
      .fwd_master(fwd_master), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
      .chk_violation(chk_violation), .owner_state(owner_state)
   );

   // {req tag, master, write, addr, expected grant, expected owner after}
   localparam logic [40:0] VEC [NV] = '{
      {4'd3, 1'b0, 1'b0, 32'h4140_0010, 1'b1, 2'd0},  // R3 A read W0
      {4'd3, 1'b1, 1'b1, 32'h4140_FFFF, 1'b1, 2'd0},  // R3 B write W0 top
      {4'd3, 1'b0, 1'b0, 32'h2477_7777, 1'b1, 2'd0},  // R3 A W3 top edge
      {4'd9, 1'b0, 1'b0, 32'h2477_7778, 1'b0, 2'd0},  // R9 just past W3
      {4'd3, 1'b1, 1'b0, 32'h2480_0000, 1'b1, 2'd0},  // R3 B W4 bottom
      {4'd7, 1'b1, 1'b1, 32'h2400_0000, 1'b0, 2'd0},  // R7 B on A window
      {4'd3, 1'b0, 1'b1, 32'h4060_0000, 1'b1, 2'd0},  // R3 A W5
      {4'd3, 1'b1, 1'b1, 32'h40C0_FFFF, 1'b1, 2'd0},  // R3 B W6
      {4'd8, 1'b0, 1'b0, 32'h2800_0004, 1'b0, 2'd0},  // R8 read claim word
      {4'd9, 1'b0, 1'b1, 32'h2800_0000, 1'b0, 2'd0},  // R9 W9 not yet
      {4'd6, 1'b1, 1'b1, 32'h2800_0008, 1'b0, 2'd0},  // R6 release w/o owner
      {4'd4, 1'b0, 1'b1, 32'h2800_0006, 1'b1, 2'd1},  // R4 A claims
      {4'd4, 1'b0, 1'b0, 32'h2800_0700, 1'b1, 2'd1},  // R4 A in W1
      {4'd4, 1'b0, 1'b0, 32'h2800_0777, 1'b1, 2'd1},  // R4 W1 top
      {4'd9, 1'b0, 1'b0, 32'h2800_0778, 1'b0, 2'd1},  // R9 past W1
      {4'd4, 1'b0, 1'b0, 32'h2800_0002, 1'b1, 2'd1},  // R4 W9
      {4'd8, 1'b1, 1'b1, 32'h2800_0004, 1'b0, 2'd1},  // R8 B claim refused
      {4'd6, 1'b1, 1'b1, 32'h2800_0008, 1'b0, 2'd1},  // R6 non-owner release
      {4'd4, 1'b1, 1'b0, 32'h2800_0800, 1'b0, 2'd1},  // R4 B has no W2 now
      {4'd8, 1'b0, 1'b0, 32'h2800_000C, 1'b1, 2'd1},  // R8 read release word
      {4'd9, 1'b0, 1'b1, 32'h2800_0004, 1'b1, 2'd1},  // R9 via W1, no move
      {4'd6, 1'b0, 1'b1, 32'h2800_000F, 1'b1, 2'd0},  // R6 A releases
      {4'd5, 1'b1, 1'b1, 32'h2800_0007, 1'b1, 2'd2},  // R5 B claims
      {4'd5, 1'b1, 1'b0, 32'h2800_0800, 1'b1, 2'd2},  // R5 W2 bottom
      {4'd5, 1'b1, 1'b1, 32'h2800_0FFF, 1'b1, 2'd2},  // R5 W2 top
      {4'd9, 1'b1, 1'b0, 32'h2800_1000, 1'b0, 2'd2},  // R9 past W2
      {4'd5, 1'b1, 1'b0, 32'h2800_0100, 1'b0, 2'd2},  // R5 W1 not for B
      {4'd5, 1'b1, 1'b0, 32'h2800_0003, 1'b1, 2'd2},  // R5 W9 top
      {4'd5, 1'b1, 1'b0, 32'h2800_0008, 1'b0, 2'd2},  // R5 W8 write-only
      {4'd7, 1'b0, 1'b0, 32'h2800_0000, 1'b0, 2'd2},  // R7 A locked out
      {4'd6, 1'b0, 1'b1, 32'h2800_0008, 1'b0, 2'd2},  // R6 non-owner release
      {4'd3, 1'b0, 1'b0, 32'h2400_0000, 1'b1, 2'd2},  // R3 base kept
      {4'd6, 1'b1, 1'b1, 32'h2800_0009, 1'b1, 2'd0}   // R6 B releases
   };

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive at negedge, decision lands at the next posedge, sampled one negedge later
   task automatic issue(input logic m, input logic w, input logic [AW-1:0] a);
      req_valid  = 1'b1;
      req_master = m;
      req_write  = w;
      req_addr   = a;
      @(negedge clk);
      req_valid  = 1'b0;
   endtask

   task automatic check_decision(input string tag, input logic g,
                                 input logic [1:0] own, input logic m,
                                 input logic w, input logic [AW-1:0] a);
      check({tag, " grant"}, {62'd0, fwd_valid, chk_violation}, {62'd0, g, ~g});
      check({tag, " owner"}, 64'(owner_state), 64'(own));
      if (g) check({tag, " fwd"}, {30'd0, fwd_master, fwd_write, fwd_addr},
                   {30'd0, m, w, a});
   endtask

   initial begin : watchdog
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      rst = 1'b1; req_valid = 1'b0; req_master = 1'b0; req_write = 1'b0;
      req_addr = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check("R1 reset outputs", {61'd0, fwd_valid, chk_violation, 1'b0},
            64'd0);
      check("R1 reset owner", 64'(owner_state), 64'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [40:0] v;
         string t;
         v = VEC[i];
         t = $sformatf("R%0d vec%0d", v[40:37], i);
         issue(v[36], v[35], v[34:3]);
         check_decision(t, v[2], v[1:0], v[36], v[35], v[34:3]);
      end

      // R2 idle cycle yields nothing
      @(negedge clk);
      check("R2 idle", {62'd0, fwd_valid, chk_violation}, 64'd0);

      // R7 violation pulse lasts one cycle
      issue(1'b1, 1'b0, 32'h0000_1000);
      check("R7 pulse high", 64'(chk_violation), 64'd1);
      @(negedge clk);
      check("R7 pulse gone", 64'(chk_violation), 64'd0);

      // R2 back-to-back: claim, then use the new right in the next cycle
      req_valid = 1'b1; req_master = 1'b0; req_write = 1'b1;
      req_addr = 32'h2800_0004;
      @(negedge clk);
      check("R2 b2b claim", {62'd0, fwd_valid, owner_state == 2'd1}, 64'd3);
      req_write = 1'b0; req_addr = 32'h2800_0010;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 b2b use", {61'd0, fwd_valid, fwd_write, chk_violation},
            64'd4);

      // R1 reset while owned
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1 reset clears owner", 64'(owner_state), 64'd0);
      issue(1'b0, 1'b0, 32'h2800_0010);
      check("R1 rights dropped", 64'(chk_violation), 64'd1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule